// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Rounding Multiplier

This block multiplies two fixed-point operands of one machine word each. It returns a product of the same word width, narrowed and saturated into a fixed-point destination format. Each operand is one of three fractional formats: a signed accumulator format with W/2 integer bits and W/2-1 fraction bits (s16.15 at the default width), a signed pure fraction (s0.31), or an unsigned pure fraction (u0.32). A pairing code chosen per transaction fixes both operand formats and the destination format. Accumulator-style pairings return the accumulator format. Pure-fraction pairings return the signed pure fraction.

The exact double-width product is narrowed by an arithmetic right shift equal to the operand fraction bits minus the destination fraction bits. A per-transaction mode selects how the discarded bits are treated: floor, nearest with ties upward, or stochastic. In stochastic mode a caller-supplied random word decides the direction, and the caller presents one fresh word with every such multiply.

Each transaction is flagged by `valid_in` and comes out two clock cycles later with `valid_out`. A new transaction can be accepted every cycle, and there is no stall path.

Top module: `fxp_round_mul`

## Requirements
- R1: `pair_sel` selects the formats as follows, each row giving operand A, operand B and the destination, with right shift S. Code 0 is s16.15 × s16.15 → s16.15, S=15. Code 1 is s16.15 × s0.31 → s16.15, S=31. Code 2 is s16.15 × u0.32 → s16.15, S=32. Code 3 is u0.32 × u0.32 → s0.31, S=33. Code 4 is u0.32 × s0.31 → s0.31, S=32. Codes 5, 6 and 7 behave exactly as code 0.
- R2: `rnd_mode` 2'b00 and 2'b11 both give the floor of the exact product, rounding toward minus infinity, so a negative product with a non-zero residual moves one LSB further from zero.
- R3: `rnd_mode` 2'b01 adds one result LSB when the highest discarded bit is 1, so an exact half rounds upward for both signs.
- R4: `rnd_mode` 2'b10 adds one result LSB exactly when `rnd_word`/2^RND_W is below the discarded residual divided by one result LSB. A residual of zero never rounds up.
- R5: A value outside the W-bit signed range saturates to 32'h7FFFFFFF or 32'h80000000. The rounding increment is added before this check, so a round-up past the maximum saturates.
- R6: `valid_out` rises exactly two cycles after the `valid_in` that produced it, results appear in order, and `result` holds its value in every cycle in which `valid_out` is low.
- R7: Unsigned operands are zero-extended, so an operand with its top bit set counts as a positive fraction of at least one half. The u0.32 × u0.32 pairing never yields a negative result.
- R8: While `rst_n` is low, `valid_out` and `result` are zero.
- R9: A product whose discarded bits are all zero is returned exactly in every mode; for example, s16.15 multiplication by 1.0 (32'h00008000) returns operand A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| pair_sel | input | 3 | Format pairing code (R1) |
| rnd_mode | input | 2 | Narrowing mode (R2 to R4) |
| op_a | input | W | Operand A raw bits |
| op_b | input | W | Operand B raw bits |
| rnd_word | input | RND_W | Uniform random word for stochastic mode |
| valid_out | output | 1 | Result valid |
| result | output | W | Saturated, narrowed product |

## Verification
The bench builds the block at W=32 and RND_W=32, the width at which every shift from 15 to 33 occurs. At this width the u0.32 × u0.32 pairing discards more bits than the random word holds, which tests whether the stochastic comparison is exact. Constrained random operands cover all eight pairing codes and four mode codes. The directed cases include both signs of the 32-bit saturation limits, a half-LSB residual of each sign, and a round-up that crosses the positive limit.

// File: rtl/fxp_mul_pkg.sv
package fxp_mul_pkg;

   typedef enum logic [1:0] {
      RND_FLOOR = 2'b00,
      RND_NEAR  = 2'b01,
      RND_STOCH = 2'b10,
      RND_ALT   = 2'b11
   } rnd_mode_e;

   // operand A is unsigned in pairings 3 and 4
   function automatic logic a_unsigned(input logic [2:0] pair);
      return (pair == 3'd3) || (pair == 3'd4);
   endfunction

   // operand B is unsigned in pairings 2 and 3
   function automatic logic b_unsigned(input logic [2:0] pair);
      return (pair == 3'd2) || (pair == 3'd3);
   endfunction

   // right shift that brings the product to the destination fraction width
   function automatic int unsigned pair_shift(input logic [2:0] pair, input int unsigned w);
      case (pair)
         3'd1:    return w - 1;
         3'd2:    return w;
         3'd3:    return w + 1;
         3'd4:    return w;
         default: return w / 2 - 1;
      endcase
   endfunction

endpackage

// File: rtl/fxp_operand_ext.sv
module fxp_operand_ext #(
   parameter int W = 32
) (
   input  logic [W-1:0]        din,
   input  logic                is_unsigned,
   output logic signed [W:0]   dout
);
   always_comb begin
      dout = is_unsigned ? {1'b0, din} : {din[W-1], din};
   end
endmodule

// File: rtl/fxp_narrow.sv
module fxp_narrow
   import fxp_mul_pkg::*;
#(
   parameter int W     = 32,
   parameter int RND_W = 32,
   parameter int PW    = 2 * (W + 1),
   parameter int SH_W  = 7
) (
   input  logic signed [PW-1:0] prod,
   input  logic [SH_W-1:0]      shamt,
   input  rnd_mode_e            mode,
   input  logic [RND_W-1:0]     rnd,
   output logic signed [PW-1:0] rounded
);
   localparam int RW = W + 1;

   logic signed [PW-1:0] floor_v;
   logic [RW-1:0]        resid;
   logic [RW-1:0]        rnd_al;
   logic                 stoch_up;
   logic                 up;

   // discarded bits left-justified into a W+1 bit fraction field
   always_comb begin
      floor_v = prod >>> shamt;
      resid   = prod[RW-1:0] << (SH_W'(RW) - shamt);
   end

   generate
      if (RND_W == RW) begin : g_rnd_full
         assign rnd_al = rnd;
      end else begin : g_rnd_pad
         assign rnd_al = {rnd, {(RW - RND_W){1'b0}}};
      end
   endgenerate

   assign stoch_up = rnd_al < resid;

   always_comb begin
      case (mode)
         RND_NEAR:  up = resid[RW-1];
         RND_STOCH: up = stoch_up;
         default:   up = 1'b0;
      endcase
      rounded = floor_v + PW'(up);
   end
endmodule

// File: rtl/fxp_saturate.sv
module fxp_saturate #(
   parameter int IW = 66,
   parameter int OW = 32
) (
   input  logic signed [IW-1:0] din,
   output logic [OW-1:0]        dout
);
   generate
      if (IW == OW) begin : g_pass
         assign dout = din;
      end else begin : g_clip
         logic [IW-OW:0] head;
         logic           fits;
         assign head = din[IW-1:OW-1];
         assign fits = (&head) || (~|head);
         always_comb begin
            if (fits)
               dout = {din[OW-1], din[OW-2:0]};
            else if (din[IW-1])
               dout = {1'b1, {(OW-1){1'b0}}};
            else
               dout = {1'b0, {(OW-1){1'b1}}};
         end
      end
   endgenerate
endmodule

// File: rtl/fxp_round_mul.sv
module fxp_round_mul
   import fxp_mul_pkg::*;
#(
   parameter int W     = 32,
   parameter int RND_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_in,
   input  logic [2:0]       pair_sel,
   input  logic [1:0]       rnd_mode,
   input  logic [W-1:0]     op_a,
   input  logic [W-1:0]     op_b,
   input  logic [RND_W-1:0] rnd_word,
   output logic             valid_out,
   output logic [W-1:0]     result
);
   localparam int PW   = 2 * (W + 1);
   localparam int SH_W = $clog2(PW + 1);

   initial begin
      assert (W >= 8 && (W % 2) == 0)
         else $error("fxp_round_mul: W must be even and at least 8");
      assert (RND_W >= 1 && RND_W <= W + 1)
         else $error("fxp_round_mul: RND_W must lie in 1..W+1");
   end

   // ---------------- stage 1: extension and full product ----------------
   logic [W-1:0]        ops   [0:1];
   logic                uns   [0:1];
   logic signed [W:0]   ext_v [0:1];
   logic signed [PW-1:0] prod_c;

   assign ops[0] = op_a;
   assign ops[1] = op_b;
   assign uns[0] = a_unsigned(pair_sel);
   assign uns[1] = b_unsigned(pair_sel);

   generate
      for (genvar k = 0; k < 2; k++) begin : g_ext
         fxp_operand_ext #(.W(W)) u_ext (
            .din         (ops[k]),
            .is_unsigned (uns[k]),
            .dout        (ext_v[k])
         );
      end
   endgenerate

   assign prod_c = ext_v[0] * ext_v[1];

   logic signed [PW-1:0] prod_q;
   logic [SH_W-1:0]      shamt_q;
   rnd_mode_e            mode_q;
   logic [RND_W-1:0]     rnd_q;
   logic                 vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_q  <= '0;
         shamt_q <= '0;
         mode_q  <= RND_FLOOR;
         rnd_q   <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= valid_in;
         if (valid_in) begin
            prod_q  <= prod_c;
            shamt_q <= SH_W'(pair_shift(pair_sel, W));
            mode_q  <= rnd_mode_e'(rnd_mode);
            rnd_q   <= rnd_word;
         end
      end
   end

   // ---------------- stage 2: narrow, round, saturate ----------------
   logic signed [PW-1:0] rounded;
   logic [W-1:0]         sat_v;

   fxp_narrow #(.W(W), .RND_W(RND_W), .PW(PW), .SH_W(SH_W)) u_narrow (
      .prod    (prod_q),
      .shamt   (shamt_q),
      .mode    (mode_q),
      .rnd     (rnd_q),
      .rounded (rounded)
   );

   fxp_saturate #(.IW(PW), .OW(W)) u_sat (
      .din  (rounded),
      .dout (sat_v)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         result    <= '0;
      end else begin
         valid_out <= vld_q;
         if (vld_q)
            result <= sat_v;
      end
   end
endmodule

// File: rtl/fxp_round_mul_chk.sv
module fxp_round_mul_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         valid_in,
   input logic [2:0]   pair_sel,
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic         valid_out,
   input logic [W-1:0] result
);
   localparam logic [W-1:0] ONE_ACC = W'(1) << (W / 2 - 1);

   // edges seen since reset released, saturating at 3
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)        age <= 2'd0;
      else if (age != 3) age <= age + 2'd1;
   end

   assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!valid_out && result == '0));

   assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2) |-> (valid_out == $past(valid_in, 2)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 1 && !valid_out) |-> $stable(result));

   assert_uns_nonneg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2 && valid_out && $past(pair_sel, 2) == 3'd3) |-> !result[W-1]);

   assert_unit_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2 && valid_out && $past(pair_sel, 2) == 3'd0 && $past(op_b, 2) == ONE_ACC)
      |-> (result == $past(op_a, 2)));
endmodule

bind fxp_round_mul fxp_round_mul_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_in  (valid_in),
   .pair_sel  (pair_sel),
   .op_a      (op_a),
   .op_b      (op_b),
   .valid_out (valid_out),
   .result    (result)
);

// File: tb/fxp_round_mul_bench.sv
module fxp_round_mul_bench;
   localparam int W     = 32;
   localparam int RND_W = 32;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         valid_in;
   logic [2:0]   pair_sel;
   logic [1:0]   rnd_mode;
   logic [31:0]  op_a, op_b, rnd_word;
   logic         valid_out;
   logic [31:0]  result;

   always #4 clk = ~clk;

   fxp_round_mul #(.W(W), .RND_W(RND_W)) u_fxp_round_mul (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .pair_sel(pair_sel),
      .rnd_mode(rnd_mode), .op_a(op_a), .op_b(op_b), .rnd_word(rnd_word),
      .valid_out(valid_out), .result(result)
   );

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] last_res = '0;
   bit          monitor_on = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected value from the requirements, in wide signed arithmetic
   function automatic logic [31:0] model(input logic [2:0] pr, input logic [1:0] md,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] rw);
      logic signed [131:0] ea, eb, p, q, res, rr, one;
      int  sh;
      bit  ua, ub, up;
      ua = 0; ub = 0; sh = 15;
      case (pr)
         3'd1: sh = 31;
         3'd2: begin sh = 32; ub = 1; end
         3'd3: begin sh = 33; ua = 1; ub = 1; end
         3'd4: begin sh = 32; ua = 1; end
         default: sh = 15;
      endcase
      ea  = ua ? {100'b0, a} : {{100{a[31]}}, a};
      eb  = ub ? {100'b0, b} : {{100{b[31]}}, b};
      p   = ea * eb;
      q   = p >>> sh;
      res = p - (q <<< sh);
      rr  = {100'b0, rw};
      one = 132'sd1;
      case (md)
         2'b01:   up = (res <<< 1) >= (one <<< sh);
         2'b10:   up = (rr <<< sh) < (res <<< 32);
         default: up = 0;
      endcase
      if (up) q = q + one;
      if (q > 132'sd2147483647)       return 32'h7FFFFFFF;
      else if (q < -132'sd2147483648) return 32'h80000000;
      else                            return q[31:0];
   endfunction

   task automatic send(input logic [2:0] pr, input logic [1:0] md, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] rw, input string tag,
                       input logic [31:0] exp);
      @(negedge clk);
      valid_in = 1'b1; pair_sel = pr; rnd_mode = md; op_a = a; op_b = b; rnd_word = rw;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic send_m(input logic [2:0] pr, input logic [1:0] md, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] rw, input string tag);
      send(pr, md, a, b, rw, tag, model(pr, md, a, b, rw));
   endtask

   task automatic idle();
      @(negedge clk);
      valid_in = 1'b0;
   endtask

   // output monitor, away from the active edge
   always @(negedge clk) begin
      if (monitor_on) begin
         if (valid_out) begin
            if (exp_q.size() == 0) begin
               chk("R6 unexpected valid_out", 32'd1, 32'd0);
            end else begin
               chk(tag_q.pop_front(), result, exp_q.pop_front());
            end
         end else begin
            chk("R6 hold while idle", result, last_res);
         end
         last_res = result;
      end
   end

   initial begin
      #(8 * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; valid_in = 1'b0; pair_sel = '0; rnd_mode = '0;
      op_a = '0; op_b = '0; rnd_word = '0;
      repeat (3) @(negedge clk);
      chk("R8 reset valid_out", {31'b0, valid_out}, 32'd0);
      chk("R8 reset result", result, 32'd0);
      rst_n = 1'b1;
      monitor_on = 1'b1;

      // R6: exact two-cycle latency
      idle(); idle();
      send(3'd0, 2'b00, 32'h00008000, 32'h00018000, 32'd0, "R1 1.0*3.0", 32'h00018000);
      idle();
      chk("R6 latency one cycle", {31'b0, valid_out}, 32'd0);
      idle();
      chk("R6 latency two cycles", {31'b0, valid_out}, 32'd1);

      // R1 pairings
      send(3'd5, 2'b00, 32'h00008000, 32'h00018000, 32'd0, "R1 code5 as code0", 32'h00018000);
      send(3'd7, 2'b01, 32'h00008000, 32'h00018000, 32'd0, "R1 code7 as code0", 32'h00018000);
      send(3'd1, 2'b00, 32'h00010000, 32'h40000000, 32'd0, "R1 acc*sfrac", 32'h00008000);
      send(3'd2, 2'b00, 32'h00008000, 32'h80000000, 32'd0, "R1 R7 acc*ufrac", 32'h00004000);
      // R7 unsigned extension
      send(3'd3, 2'b00, 32'h80000000, 32'h40000000, 32'd0, "R7 ufrac*ufrac", 32'h10000000);
      send(3'd4, 2'b00, 32'h80000000, 32'h80000000, 32'd0, "R7 ufrac*sfrac", 32'hC0000000);
      // R2 / R3 half-LSB residual, negative
      send(3'd0, 2'b00, 32'hFFFFFFFF, 32'h00004000, 32'd0, "R2 floor negative", 32'hFFFFFFFF);
      send(3'd0, 2'b11, 32'hFFFFFFFF, 32'h00004000, 32'd0, "R2 mode3 as floor", 32'hFFFFFFFF);
      send(3'd0, 2'b01, 32'hFFFFFFFF, 32'h00004000, 32'd0, "R3 tie up negative", 32'h00000000);
      send(3'd0, 2'b01, 32'hAAAAAAAB, 32'h0000C000, 32'd0, "R3 tie up at min", 32'h80000001);
      send(3'd0, 2'b00, 32'hAAAAAAAB, 32'h0000C000, 32'd0, "R2 floor at min", 32'h80000000);
      // R4 stochastic at half residual
      send(3'd0, 2'b10, 32'hFFFFFFFF, 32'h00004000, 32'h7FFFFFFF, "R4 rnd below", 32'h00000000);
      send(3'd0, 2'b10, 32'hFFFFFFFF, 32'h00004000, 32'h80000000, "R4 rnd equal", 32'hFFFFFFFF);
      send(3'd0, 2'b10, 32'h00018000, 32'h00008000, 32'h00000000, "R4 R9 zero resid", 32'h00018000);
      // R5 saturation and round-then-saturate
      send(3'd0, 2'b00, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0, "R5 sat max", 32'h7FFFFFFF);
      send(3'd0, 2'b00, 32'h80000000, 32'h7FFFFFFF, 32'd0, "R5 sat min", 32'h80000000);
      send(3'd0, 2'b01, 32'h55555555, 32'h0000C000, 32'd0, "R5 round past max", 32'h7FFFFFFF);
      send(3'd3, 2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, "R7 near one", 32'h7FFFFFFF);
      // R9 exact products in all modes
      for (int m = 0; m < 4; m++)
         send(3'd0, 2'(m), 32'hDEAD1234, 32'h00008000, 32'hFFFFFFFF, "R9 times one", 32'hDEAD1234);
      idle(); idle(); idle();

      // constrained random traffic
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a, b;
         logic [2:0]  pr;
         pr = 3'($urandom % 8);
         a  = $urandom;
         b  = $urandom;
         if ($urandom % 4 == 0) a = a >>> ($urandom % 24);
         if ($urandom % 4 == 0) b = {{16{b[15]}}, b[15:0]};
         send_m(pr, 2'($urandom % 4), a, b, $urandom, "R1 R2 R3 R4 R5 random");
         if ($urandom % 4 == 0) idle();
      end
      idle(); idle(); idle(); idle();
      chk("R6 all results delivered", 32'(exp_q.size()), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule